// File: doc/BRIEF.md
# Narrow-Bus Wide-Word Host Port

This block connects a 16-bit strobed host bus to a 64-bit internal data path. The host runs one bus cycle per assertion of an active-low strobe. At the start of each cycle the port latches two control lines, a write line and a command/data line. Those two lines pick one of four cycle types. A third line, the chain enable, is latched at the same moment and passed on to the rest of the device.

Data cycles move one 16-bit slice at a time. A data read presents one slice of the 64-bit word offered by the array side. A data write fills one slice of a 64-bit assembly buffer. The slice is chosen by a read segment counter for reads and a write segment counter for writes. Each counter advances when the strobe is released. When the fourth write slice is in, the port hands the whole word onward with a one-clock valid pulse. Command writes load a 16-bit instruction. Command reads return a 32-bit status word one half at a time.

The strobe and the control lines are sampled in the port's own clock domain. The strobe's falling and rising edges are found by comparing the strobe with its value on the previous clock.

Top module: `hb_wide_port`

## Requirements
- R1: The cycle type is latched in the first clock in which the strobe is seen low. Changes on the write and command/data lines later in the same bus cycle have no effect on that cycle.
- R2: The type is decoded from {write line, command/data line}. 00 is a command write, 01 a data write, 10 a command read and 11 a data read.
- R3: The data output enable is high only while the strobe is low during a read cycle, starting one clock after the strobe falls. It drops in the same clock in which the strobe goes high. It stays low for the whole of any write cycle.
- R4: A data read drives slice N of the array word, where slice 0 is bits 15:0 and N is the read segment counter. The read counter advances by one when the cycle ends.
- R5: A data write stores the last bus value sampled while the strobe was low into slice N of the assembly buffer, where N is the write segment counter. The write counter advances by one when the cycle ends.
- R6: Both segment counters wrap from 3 to 0. The clock after the fourth data write ends, the assembled word appears with a one-clock valid pulse, slice 0 in bits 15:0. There is no pulse after the first three writes.
- R7: A command write loads the instruction output and pulses its valid for one clock after the cycle ends. Command cycles leave both segment counters unchanged.
- R8: Command reads return status bits 15:0 first, then bits 31:16, and keep alternating on later command reads.
- R9: The chain enable output is the inverse of the active-low chain line as latched at the start of the last bus cycle.
- R10: After reset both segment counters are 0, the output enable and both valid pulses are low, and the next command read returns the low status half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en_n | input | 1 | Active-low cycle strobe |
| bus_wr_n | input | 1 | Low for write cycles, high for read cycles |
| bus_cmd_n | input | 1 | Low for command cycles, high for data cycles |
| bus_chain_n | input | 1 | Active-low chain enable request |
| dq_in | input | 16 | Bus data from the host |
| dq_out | output | 16 | Bus data to the host |
| dq_oe | output | 1 | Bus output enable; low means high impedance |
| rd_word | input | 64 | Word offered by the array side for data reads |
| status_word | input | 32 | Status word for command reads |
| wr_word | output | 64 | Assembled write word |
| wr_word_vld | output | 1 | One-clock pulse when wr_word is complete |
| instr | output | 16 | Last instruction written |
| instr_vld | output | 1 | One-clock pulse when instr is loaded |
| chain_en | output | 1 | Latched chain enable, active high |
| src_seg | output | 2 | Read segment counter |
| dst_seg | output | 2 | Write segment counter |

## Verification
The strobe's falling edge takes effect at the first rising clock edge that sees it low, so read data and the output enable are valid one clock after the strobe drops. The bench samples them at the falling clock edge after that. The release is also seen at a single clock edge. Counter steps, the instruction and word valid pulses, and the status-half toggle all become visible right after that edge, and the pulses last until the next one. The bench therefore reads them at the intervening falling clock edge, and checks that they are gone one clock later. The output enable follows the strobe without a register on release, so it is checked one time step after the strobe rises.

// File: rtl/hb_pkg.sv
package hb_pkg;
    // Encoding is {write line, command/data line}, both active low.
    typedef enum logic [1:0] {
        CYC_CMD_WR = 2'b00,
        CYC_DAT_WR = 2'b01,
        CYC_CMD_RD = 2'b10,
        CYC_DAT_RD = 2'b11
    } cyc_t;
endpackage

// File: rtl/hb_strobe.sv
module hb_strobe
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic wr_n,
    input  logic cmd_n,
    input  logic chain_n,
    output logic active,
    output logic start,
    output logic finish,
    output cyc_t cyc,
    output logic chain_en
);
    typedef struct packed {
        logic active;
        cyc_t cyc;
        logic chain_n;
    } st_s;

    st_s st_d, st_q;

    assign start  = !en_n && !st_q.active;
    assign finish = en_n && st_q.active;

    always_comb begin
        st_d        = st_q;
        st_d.active = !en_n;
        if (start) begin
            st_d.cyc     = cyc_t'({wr_n, cmd_n});
            st_d.chain_n = chain_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active  <= 1'b0;
            st_q.cyc     <= CYC_DAT_RD;
            st_q.chain_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.active;
    assign cyc      = st_q.cyc;
    assign chain_en = !st_q.chain_n;

    AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !en_n) |=> $stable(st_q.cyc)); // R1
    AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.active); // R1
endmodule

// File: rtl/hb_segctr.sv
module hb_segctr #(
    parameter int unsigned N = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  step,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0]  cnt
);
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1;
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_SEG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1))); // R6
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/hb_wordasm.sv
module hb_wordasm #(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned SEGS  = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        load,
    input  logic [((SEGS > 1) ? $clog2(SEGS) : 1)-1:0]  sel,
    input  logic [BUS_W-1:0]                            din,
    output logic [BUS_W*SEGS-1:0]                       word,
    output logic                                        word_vld
);
    localparam int unsigned SW = (SEGS > 1) ? $clog2(SEGS) : 1;
    localparam logic [SW-1:0] LAST = SW'(SEGS - 1);

    logic [BUS_W*SEGS-1:0] buf_d, buf_q, word_d, word_q;
    logic                  vld_d, vld_q;

    for (genvar g = 0; g < SEGS; g++) begin : g_slice
        always_comb begin
            buf_d[g*BUS_W +: BUS_W] = (load && sel == SW'(g)) ? din
                                                              : buf_q[g*BUS_W +: BUS_W];
        end
    end

    always_comb begin
        vld_d  = load && (sel == LAST);
        word_d = vld_d ? buf_d : word_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            buf_q  <= buf_d;
            word_q <= word_d;
            vld_q  <= vld_d;
        end
    end

    assign word     = word_q;
    assign word_vld = vld_q;

    AST_WORD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(load && sel == LAST)); // R6
    AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q); // R6
endmodule

// File: rtl/hb_wide_port.sv
module hb_wide_port
    import hb_pkg::*;
#(
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned STAT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en_n,
    input  logic                 bus_wr_n,
    input  logic                 bus_cmd_n,
    input  logic                 bus_chain_n,
    input  logic [BUS_W-1:0]     dq_in,
    output logic [BUS_W-1:0]     dq_out,
    output logic                 dq_oe,
    input  logic [WORD_W-1:0]    rd_word,
    input  logic [STAT_W-1:0]    status_word,
    output logic [WORD_W-1:0]    wr_word,
    output logic                 wr_word_vld,
    output logic [BUS_W-1:0]     instr,
    output logic                 instr_vld,
    output logic                 chain_en,
    output logic [((WORD_W/BUS_W > 1) ? $clog2(WORD_W/BUS_W) : 1)-1:0] src_seg,
    output logic [((WORD_W/BUS_W > 1) ? $clog2(WORD_W/BUS_W) : 1)-1:0] dst_seg
);
    localparam int unsigned SEGS   = WORD_W / BUS_W;
    localparam int unsigned SW     = (SEGS > 1) ? $clog2(SEGS) : 1;
    localparam int unsigned HALVES = STAT_W / BUS_W;
    localparam int unsigned HW     = (HALVES > 1) ? $clog2(HALVES) : 1;

    logic   active, start, finish;
    cyc_t   cyc;
    logic   [SW-1:0] src_q, dst_q;
    logic   [HW-1:0] stat_sel;
    logic   is_read;

    typedef struct packed {
        logic [BUS_W-1:0] hold;
        logic [BUS_W-1:0] instr;
        logic             instr_vld;
    } reg_s;

    reg_s r_d, r_q;

    hb_strobe i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (bus_en_n),
        .wr_n     (bus_wr_n),
        .cmd_n    (bus_cmd_n),
        .chain_n  (bus_chain_n),
        .active   (active),
        .start    (start),
        .finish   (finish),
        .cyc      (cyc),
        .chain_en (chain_en)
    );

    hb_segctr #(.N(SEGS)) i_src_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (finish && cyc == CYC_DAT_RD),
        .cnt  (src_q)
    );

    hb_segctr #(.N(SEGS)) i_dst_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (finish && cyc == CYC_DAT_WR),
        .cnt  (dst_q)
    );

    hb_segctr #(.N(HALVES)) i_stat_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (finish && cyc == CYC_CMD_RD),
        .cnt  (stat_sel)
    );

    hb_wordasm #(.BUS_W(BUS_W), .SEGS(SEGS)) i_wordasm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (finish && cyc == CYC_DAT_WR),
        .sel      (dst_q),
        .din      (r_q.hold),
        .word     (wr_word),
        .word_vld (wr_word_vld)
    );

    always_comb begin
        r_d           = r_q;
        r_d.instr_vld = 1'b0;
        if (!bus_en_n) r_d.hold = dq_in;
        if (finish && cyc == CYC_CMD_WR) begin
            r_d.instr     = r_q.hold;
            r_d.instr_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign is_read   = (cyc == CYC_CMD_RD) || (cyc == CYC_DAT_RD);
    assign dq_oe     = !bus_en_n && active && is_read;
    assign dq_out    = (cyc == CYC_CMD_RD) ? status_word[stat_sel*BUS_W +: BUS_W]
                                           : rd_word[src_q*BUS_W +: BUS_W];
    assign instr     = r_q.instr;
    assign instr_vld = r_q.instr_vld;
    assign src_seg   = src_q;
    assign dst_seg   = dst_q;

    AST_INSTR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |-> $past(finish && cyc == CYC_CMD_WR)); // R7
    AST_STAT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && cyc == CYC_CMD_RD) |=> (stat_sel != $past(stat_sel))); // R8
    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (cyc == CYC_CMD_WR || cyc == CYC_DAT_WR)) |-> !dq_oe); // R3
    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!bus_en_n)); // R3
endmodule

// File: tb/test_hb_wide_port.sv
module test_hb_wide_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en_n = 1'b1, bus_wr_n = 1'b1, bus_cmd_n = 1'b1, bus_chain_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [63:0] rd_word = 64'h4444_3333_2222_1111;
    logic [31:0] status_word = 32'hBEEF_CAFE;
    logic [63:0] wr_word;
    logic        wr_word_vld;
    logic [15:0] instr;
    logic        instr_vld;
    logic        chain_en;
    logic [1:0]  src_seg, dst_seg;

    int total = 0;
    int bad = 0;

    // Results of the last bus cycle
    logic [15:0] s_data;
    logic        s_oe_mid, s_oe_mid2, s_oe_off, s_ivld, s_wvld, s_ivld_next, s_wvld_next;

    always #5 clk = ~clk;

    hb_wide_port i_hb_wide_port (
        .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_wr_n(bus_wr_n),
        .bus_cmd_n(bus_cmd_n), .bus_chain_n(bus_chain_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .rd_word(rd_word), .status_word(status_word),
        .wr_word(wr_word), .wr_word_vld(wr_word_vld), .instr(instr),
        .instr_vld(instr_vld), .chain_en(chain_en), .src_seg(src_seg), .dst_seg(dst_seg)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; flip inverts write and command lines after the first sample.
    task automatic bus_cyc(input logic wr_n, input logic cmd_n, input logic chain_n,
                           input logic [15:0] d, input bit flip);
        @(negedge clk);
        bus_en_n = 1'b0; bus_wr_n = wr_n; bus_cmd_n = cmd_n;
        bus_chain_n = chain_n; dq_in = d;
        @(posedge clk); @(negedge clk);
        s_oe_mid = dq_oe; s_data = dq_out;
        if (flip) begin bus_wr_n = ~wr_n; bus_cmd_n = ~cmd_n; bus_chain_n = ~chain_n; end
        @(posedge clk); @(negedge clk);
        s_oe_mid2 = dq_oe;
        bus_en_n = 1'b1;
        #1 s_oe_off = dq_oe;
        @(posedge clk); @(negedge clk);
        s_ivld = instr_vld; s_wvld = wr_word_vld;
        bus_wr_n = 1'b1; bus_cmd_n = 1'b1; bus_chain_n = 1'b1;
        @(posedge clk); @(negedge clk);
        s_ivld_next = instr_vld; s_wvld_next = wr_word_vld;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_seg == 0 && dst_seg == 0, "R10 counters", {src_seg, dst_seg}, 0);
        chk(!dq_oe && !instr_vld && !wr_word_vld, "R10 outputs low",
            {dq_oe, instr_vld, wr_word_vld}, 0);
    endtask

    task automatic t_status;
        bus_cyc(1'b1, 1'b0, 1'b1, 16'h0, 1'b0);
        chk(s_oe_mid && s_data == 16'hCAFE, "R8 R10 status low half first", s_data, 16'hCAFE);
        chk(!s_oe_off, "R3 oe drops with strobe", s_oe_off, 0);
        bus_cyc(1'b1, 1'b0, 1'b1, 16'h0, 1'b0);
        chk(s_data == 16'hBEEF, "R8 status high half", s_data, 16'hBEEF);
        bus_cyc(1'b1, 1'b0, 1'b1, 16'h0, 1'b0);
        chk(s_data == 16'hCAFE, "R8 status alternates", s_data, 16'hCAFE);
        chk(src_seg == 0 && dst_seg == 0, "R7 command read keeps counters",
            {src_seg, dst_seg}, 0);
    endtask

    task automatic t_data_read;
        for (int i = 0; i < 5; i++) begin
            logic [15:0] e;
            e = rd_word[(i % 4) * 16 +: 16];
            bus_cyc(1'b1, 1'b1, 1'b1, 16'h0, 1'b0);
            chk(s_oe_mid && s_data == e, "R4 R2 data read slice", s_data, e);
            chk(src_seg == 2'((i + 1) % 4), "R4 R6 read counter", src_seg, (i + 1) % 4);
        end
    endtask

    task automatic t_data_write;
        logic [15:0] v [4] = '{16'hA0A0, 16'hB1B1, 16'hC2C2, 16'hD3D3};
        for (int i = 0; i < 4; i++) begin
            bus_cyc(1'b0, 1'b1, 1'b1, v[i], 1'b0);
            chk(!s_oe_mid && !s_oe_mid2, "R3 no oe on data write", s_oe_mid, 0);
            chk(dst_seg == 2'((i + 1) % 4), "R5 R6 write counter", dst_seg, (i + 1) % 4);
            chk(s_wvld == (i == 3), "R6 word valid after fourth", s_wvld, i == 3);
        end
        chk(wr_word == 64'hD3D3_C2C2_B1B1_A0A0, "R5 R6 assembled word", wr_word,
            64'hD3D3_C2C2_B1B1_A0A0);
        chk(!s_wvld_next, "R6 valid lasts one clock", s_wvld_next, 0);
    endtask

    task automatic t_cmd_write;
        bus_cyc(1'b0, 1'b0, 1'b1, 16'h5A3C, 1'b0);
        chk(s_ivld && instr == 16'h5A3C, "R7 instruction loaded", instr, 16'h5A3C);
        chk(!s_ivld_next, "R7 instr valid one clock", s_ivld_next, 0);
        chk(src_seg == 1 && dst_seg == 0, "R7 command write keeps counters",
            {src_seg, dst_seg}, 4'b0100);
    endtask

    task automatic t_latch_ignore;
        // Starts as command write with chain low, lines flip mid-cycle.
        bus_cyc(1'b0, 1'b0, 1'b0, 16'h1234, 1'b1);
        chk(!s_oe_mid2, "R1 flip does not turn read on", s_oe_mid2, 0);
        chk(s_ivld && instr == 16'h1234, "R1 R2 type kept as command write", instr, 16'h1234);
        chk(chain_en == 1'b1, "R9 chain latched at start", chain_en, 1);
        chk(src_seg == 1 && dst_seg == 0, "R1 counters untouched", {src_seg, dst_seg}, 4'b0100);
        bus_cyc(1'b1, 1'b1, 1'b1, 16'h0, 1'b0);
        chk(chain_en == 1'b0, "R9 chain released", chain_en, 0);
        chk(s_data == 16'h2222, "R4 read after command cycles", s_data, 16'h2222);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_status();
                t_data_read();
                t_data_write();
                t_cmd_write();
                t_latch_ignore();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule